// File: doc/BRIEF.md
# DMA Channel Address Sequencer

This block holds two byte-stream DMA channels, one for a receive path and one for a transmit path, of the kind that feed a serial peripheral. Software programs each channel with a buffer start address, a length in bytes and a configuration word carrying enable, continuous and clear controls. From then on, each request raised by the peripheral side produces one byte transfer strobe carrying the current buffer address. The channel then advances its address and reduces its remaining count.

When the count runs out, the channel either stops or, in continuous mode, reloads the programmed start address and length and carries on without software help. In both cases it raises an end-of-buffer pulse. Reads of the address and size registers return the live current address and the bytes still to transfer. A pending status bit shows whether the channel still has work. The two channels share only the register port, so full-duplex traffic runs with no interaction between them.

Top module: `dma_chan_seq`

## Requirements
- R1: After a synchronous reset every register reads zero, both channels are disabled, and no transfer strobe or end pulse is raised.
- R2: Register offsets are 0x00 (address), 0x04 (size) and 0x08 (config) for receive, and 0x10, 0x14 and 0x18 for transmit. Writing the 12-bit address field (bits 11:0) sets both the start and current address. Writing the 16-bit size field (bits 15:0) sets both the start length and the remaining count. Reads return the current address and remaining count, with the upper bits zero.
- R3: A request that is accepted produces, one cycle later, a transfer strobe that carries the address in use before the step. The address then goes up by one and the remaining count goes down by one.
- R4: On the transfer that takes the count from 1 to 0, a channel with continuous = 0 clears its enable and stops. A channel with continuous = 1 reloads its start address and start length and stays enabled.
- R5: A config write with bit 6 set clears enable and zeroes the remaining count, which drops pending. This holds even when bit 4 is set in the same write.
- R6: The end-of-buffer pulse is high for exactly the cycle of the strobe of the last transfer of a buffer, in both modes.
- R7: A request is ignored while the channel is disabled or its remaining count is zero. No strobe is raised, and the address and count do not change.
- R8: A config read returns enable in bit 4 and continuous in bit 0. Bit 5 is pending, which is set when the channel is enabled and its count is nonzero. Bit 6 always reads 0.
- R9: The channels are independent. Requests on both in the same cycle are both served, and activity on one never changes the other's registers.
- R10: When a register write targets a channel, the write takes that cycle and a request on that channel in the same cycle is ignored.
- R11: Offsets outside the six listed registers read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Byte offset for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| rx_req | input | 1 | Receive-side byte request |
| rx_xfer_valid | output | 1 | Receive transfer strobe |
| rx_xfer_addr | output | 12 | Address of the receive transfer |
| rx_done | output | 1 | Receive end-of-buffer pulse |
| tx_req | input | 1 | Transmit-side byte request |
| tx_xfer_valid | output | 1 | Transmit transfer strobe |
| tx_xfer_addr | output | 12 | Address of the transmit transfer |
| tx_done | output | 1 | Transmit end-of-buffer pulse |

## Verification
The assertions assume that requests are single-cycle, level-sampled inputs. They also assume that the register port carries at most one write per cycle, so a channel's next state follows only from one write or one accepted request. The stimulus drives every input at the falling edge, so each request or write is seen at exactly one rising edge. It keeps buffers away from the top of the 12-bit address space, so address steps never wrap. Collisions between a write and a request are created on purpose, in a single dedicated scenario only.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

    parameter int unsigned CH_ADDR_W = 12;
    parameter int unsigned CH_SIZE_W = 16;
    parameter int unsigned REG_DW    = 32;
    parameter int unsigned REG_AW    = 6;
    parameter int unsigned N_CH      = 2;

    localparam int unsigned CH_IDX_W = $clog2(N_CH);

    // config word bit positions
    localparam int unsigned CFG_CONT_BIT = 0;
    localparam int unsigned CFG_EN_BIT   = 4;
    localparam int unsigned CFG_PEND_BIT = 5;
    localparam int unsigned CFG_CLR_BIT  = 6;

    typedef enum logic [1:0] {
        FLD_ADDR = 2'd0,
        FLD_SIZE = 2'd1,
        FLD_CFG  = 2'd2,
        FLD_NONE = 2'd3
    } field_e;

    typedef struct packed {
        logic                hit;
        logic [CH_IDX_W-1:0] ch;
        field_e              fld;
    } reg_sel_t;

    typedef struct packed {
        logic [CH_ADDR_W-1:0] start_addr;
        logic [CH_SIZE_W-1:0] start_size;
        logic [CH_ADDR_W-1:0] cur_addr;
        logic [CH_SIZE_W-1:0] remaining;
        logic                 en;
        logic                 cont;
    } chan_state_t;

    typedef struct packed {
        logic [CH_ADDR_W-1:0] cur_addr;
        logic [CH_SIZE_W-1:0] remaining;
        logic                 en;
        logic                 cont;
        logic                 pending;
    } chan_view_t;

    // offset layout: bit 4 picks the channel, bits 3:2 the field
    function automatic reg_sel_t decode_offset(input logic [REG_AW-1:0] a);
        reg_sel_t s;
        s.ch  = a[4 +: CH_IDX_W];
        s.fld = field_e'(a[3:2]);
        s.hit = (a[1:0] == 2'b00) && (a[REG_AW-1:5] == '0) && (a[3:2] != 2'd3);
        if (!s.hit) s.fld = FLD_NONE;
        return s;
    endfunction

    function automatic logic [REG_DW-1:0] cfg_word(input chan_view_t v);
        logic [REG_DW-1:0] w;
        w = '0;
        w[CFG_CONT_BIT] = v.cont;
        w[CFG_EN_BIT]   = v.en;
        w[CFG_PEND_BIT] = v.pending;
        return w;
    endfunction

endpackage

// File: rtl/dcs_regdec.sv
module dcs_regdec
    import dcs_pkg::*;
#(
    parameter int unsigned AW = REG_AW,
    parameter int unsigned DW = REG_DW,
    parameter int unsigned NC = N_CH
) (
    input  logic           reg_wr,
    input  logic [AW-1:0]  reg_addr,
    input  chan_view_t     views [NC],
    output logic [NC-1:0]  wr_strobe,
    output field_e         wr_field,
    output logic [DW-1:0]  reg_rdata
);

    reg_sel_t sel;

    always_comb begin
        sel      = decode_offset(reg_addr);
        wr_field = sel.fld;
    end

    for (genvar c = 0; c < NC; c++) begin : g_strobe
        assign wr_strobe[c] = reg_wr && sel.hit && (sel.ch == c[CH_IDX_W-1:0]);
    end

    always_comb begin
        reg_rdata = '0;
        if (sel.hit) begin
            unique case (sel.fld)
                FLD_ADDR: reg_rdata[CH_ADDR_W-1:0] = views[sel.ch].cur_addr;
                FLD_SIZE: reg_rdata[CH_SIZE_W-1:0] = views[sel.ch].remaining;
                FLD_CFG:  reg_rdata = cfg_word(views[sel.ch]);
                default:  reg_rdata = '0;
            endcase
        end
    end

    // R9: a write never reaches both channels
    always_comb begin
        a_one_target_r9: assert ($onehot0(wr_strobe));
    end

endmodule

// File: rtl/dcs_channel.sv
module dcs_channel
    import dcs_pkg::*;
#(
    parameter int unsigned AW = CH_ADDR_W,
    parameter int unsigned SW = CH_SIZE_W,
    parameter int unsigned DW = REG_DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  field_e        wr_field,
    input  logic [DW-1:0] wr_data,
    input  logic          req,
    output chan_view_t    view,
    output logic          xfer_valid,
    output logic [AW-1:0] xfer_addr,
    output logic          done
);

    localparam logic [SW-1:0] ONE = SW'(1);

    chan_state_t st, nxt;
    logic        accept;
    logic        last;

    assign accept = req && st.en && (st.remaining != '0) && !wr_en;
    assign last   = accept && (st.remaining == ONE);

    always_comb begin
        nxt = st;
        if (wr_en) begin
            unique case (wr_field)
                FLD_ADDR: begin
                    nxt.start_addr = wr_data[AW-1:0];
                    nxt.cur_addr   = wr_data[AW-1:0];
                end
                FLD_SIZE: begin
                    nxt.start_size = wr_data[SW-1:0];
                    nxt.remaining  = wr_data[SW-1:0];
                end
                FLD_CFG: begin
                    nxt.cont = wr_data[CFG_CONT_BIT];
                    if (wr_data[CFG_CLR_BIT]) begin
                        nxt.en        = 1'b0;
                        nxt.remaining = '0;
                    end else begin
                        nxt.en = wr_data[CFG_EN_BIT];
                    end
                end
                default: ;
            endcase
        end else if (accept) begin
            if (last && st.cont) begin
                nxt.cur_addr  = st.start_addr;
                nxt.remaining = st.start_size;
            end else begin
                nxt.cur_addr  = st.cur_addr + AW'(1);
                nxt.remaining = st.remaining - ONE;
                if (last) nxt.en = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= '0;
            xfer_valid <= 1'b0;
            xfer_addr  <= '0;
            done       <= 1'b0;
        end else begin
            st         <= nxt;
            xfer_valid <= accept;
            done       <= last;
            if (accept) xfer_addr <= st.cur_addr;
        end
    end

    always_comb begin
        view.cur_addr  = st.cur_addr;
        view.remaining = st.remaining;
        view.en        = st.en;
        view.cont      = st.cont;
        view.pending   = st.en && (st.remaining != '0);
    end

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (!st.en && st.remaining == '0 && !xfer_valid && !done));

    p_step_r3: assert property (@(posedge clk) disable iff (rst)
        (accept && !last) |=> (st.cur_addr == $past(st.cur_addr) + AW'(1)
                               && st.remaining == $past(st.remaining) - ONE
                               && xfer_valid && xfer_addr == $past(st.cur_addr)));

    p_reload_r4: assert property (@(posedge clk) disable iff (rst)
        (last && st.cont) |=> (st.cur_addr == $past(st.start_addr)
                               && st.remaining == $past(st.start_size) && st.en));

    p_stop_r4: assert property (@(posedge clk) disable iff (rst)
        (last && !st.cont) |=> (!st.en && st.remaining == '0));

    p_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_field == FLD_CFG && wr_data[CFG_CLR_BIT])
            |=> (!st.en && st.remaining == '0 && !view.pending));

    p_done_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> xfer_valid);

    p_ignore_r7: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && (!st.en || st.remaining == '0))
            |=> ($stable(st.cur_addr) && $stable(st.remaining) && !xfer_valid));

    p_write_wins_r10: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !xfer_valid);

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
    import dcs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic [REG_DW-1:0]    reg_wdata,
    output logic [REG_DW-1:0]    reg_rdata,
    input  logic                 rx_req,
    output logic                 rx_xfer_valid,
    output logic [CH_ADDR_W-1:0] rx_xfer_addr,
    output logic                 rx_done,
    input  logic                 tx_req,
    output logic                 tx_xfer_valid,
    output logic [CH_ADDR_W-1:0] tx_xfer_addr,
    output logic                 tx_done
);

    localparam int unsigned RX = 0;
    localparam int unsigned TX = 1;

    chan_view_t           views [N_CH];
    logic [N_CH-1:0]      wr_strobe;
    field_e               wr_field;
    logic [N_CH-1:0]      req_v;
    logic [N_CH-1:0]      xv_v;
    logic [N_CH-1:0]      done_v;
    logic [CH_ADDR_W-1:0] xa_v [N_CH];

    assign req_v[RX] = rx_req;
    assign req_v[TX] = tx_req;

    dcs_regdec #(.AW(REG_AW), .DW(REG_DW), .NC(N_CH)) u_regdec (
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .views     (views),
        .wr_strobe (wr_strobe),
        .wr_field  (wr_field),
        .reg_rdata (reg_rdata)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        dcs_channel #(.AW(CH_ADDR_W), .SW(CH_SIZE_W), .DW(REG_DW)) u_ch (
            .clk        (clk),
            .rst        (rst),
            .wr_en      (wr_strobe[c]),
            .wr_field   (wr_field),
            .wr_data    (reg_wdata),
            .req        (req_v[c]),
            .view       (views[c]),
            .xfer_valid (xv_v[c]),
            .xfer_addr  (xa_v[c]),
            .done       (done_v[c])
        );
    end

    assign rx_xfer_valid = xv_v[RX];
    assign rx_xfer_addr  = xa_v[RX];
    assign rx_done       = done_v[RX];
    assign tx_xfer_valid = xv_v[TX];
    assign tx_xfer_addr  = xa_v[TX];
    assign tx_done       = done_v[TX];

    // R9: with no write and no request on a channel, its state holds
    p_quiet_rx_r9: assert property (@(posedge clk) disable iff (rst)
        (!wr_strobe[RX] && !rx_req) |=> ($stable(views[RX].cur_addr) && $stable(views[RX].remaining)));

    p_quiet_tx_r9: assert property (@(posedge clk) disable iff (rst)
        (!wr_strobe[TX] && !tx_req) |=> ($stable(views[TX].cur_addr) && $stable(views[TX].remaining)));

endmodule

// File: tb/dma_chan_seq_tb.sv
module dma_chan_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr;
    logic [5:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        rx_req, tx_req;
    logic        rx_xfer_valid, tx_xfer_valid;
    logic [11:0] rx_xfer_addr, tx_xfer_addr;
    logic        rx_done, tx_done;

    int checks = 0;
    int errors = 0;

    localparam logic [5:0] RX_A = 6'h00, RX_S = 6'h04, RX_C = 6'h08;
    localparam logic [5:0] TX_A = 6'h10, TX_S = 6'h14, TX_C = 6'h18;

    always #5 clk = ~clk;

    dma_chan_seq dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rx_req(rx_req), .rx_xfer_valid(rx_xfer_valid), .rx_xfer_addr(rx_xfer_addr), .rx_done(rx_done),
        .tx_req(tx_req), .tx_xfer_valid(tx_xfer_valid), .tx_xfer_addr(tx_xfer_addr), .tx_done(tx_done)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic rd_chk(input string tag, input logic [5:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(tag, d, exp);
    endtask

    // one request pulse; outputs sampled just after the accepting edge
    task automatic pulse(input logic r, input logic t,
                         output logic rv, output logic [11:0] ra, output logic rd_o,
                         output logic tv, output logic [11:0] ta, output logic td);
        @(negedge clk);
        rx_req = r; tx_req = t;
        @(posedge clk);
        #1;
        rv = rx_xfer_valid; ra = rx_xfer_addr; rd_o = rx_done;
        tv = tx_xfer_valid; ta = tx_xfer_addr; td = tx_done;
        @(negedge clk);
        rx_req = 1'b0; tx_req = 1'b0;
    endtask

    task automatic t_reset;
        rd_chk("R1 rx addr", RX_A, 0);
        rd_chk("R1 rx size", RX_S, 0);
        rd_chk("R1 rx cfg",  RX_C, 0);
        rd_chk("R1 tx cfg",  TX_C, 0);
        chk("R1 strobes", {rx_xfer_valid, rx_done, tx_xfer_valid, tx_done}, 0);
    endtask

    task automatic t_single_buffer;
        logic rv, rdn, tv, tdn; logic [11:0] ra, ta;
        wr(RX_A, 32'hFFFF_F100);
        wr(RX_S, 32'hABCD_0003);
        rd_chk("R2 addr readback", RX_A, 32'h100);
        rd_chk("R2 size readback", RX_S, 32'h3);
        rd_chk("R8 cfg idle", RX_C, 32'h0);
        wr(RX_C, 32'h10);
        rd_chk("R8 cfg pending", RX_C, 32'h30);
        for (int i = 0; i < 3; i++) begin
            pulse(1'b1, 1'b0, rv, ra, rdn, tv, ta, tdn);
            chk("R3 strobe", rv, 1);
            chk("R3 addr", ra, 32'h100 + i);
            chk("R6 done only on last", rdn, (i == 2));
            chk("R9 tx untouched", tv, 0);
            if (i < 2) begin
                rd_chk("R3 live addr", RX_A, 32'h101 + i);
                rd_chk("R3 live size", RX_S, 32'h2 - i);
            end
        end
        rd_chk("R4 stop cfg", RX_C, 32'h0);
        rd_chk("R4 stop size", RX_S, 32'h0);
        pulse(1'b1, 1'b0, rv, ra, rdn, tv, ta, tdn);
        chk("R7 no strobe after stop", rv, 0);
        rd_chk("R7 addr held", RX_A, 32'h103);
    endtask

    task automatic t_continuous;
        logic rv, rdn, tv, tdn; logic [11:0] ra, ta;
        wr(TX_A, 32'h7FE);
        wr(TX_S, 32'h2);
        wr(TX_C, 32'h11);
        rd_chk("R8 cfg cont", TX_C, 32'h31);
        pulse(1'b0, 1'b1, rv, ra, rdn, tv, ta, tdn);
        chk("R3 tx addr0", ta, 32'h7FE);
        chk("R6 tx no done", tdn, 0);
        pulse(1'b0, 1'b1, rv, ra, rdn, tv, ta, tdn);
        chk("R3 tx addr1", ta, 32'h7FF);
        chk("R6 tx done cont", tdn, 1);
        rd_chk("R4 reload addr", TX_A, 32'h7FE);
        rd_chk("R4 reload size", TX_S, 32'h2);
        rd_chk("R4 still enabled", TX_C, 32'h31);
        pulse(1'b0, 1'b1, rv, ra, rdn, tv, ta, tdn);
        chk("R4 restart addr", ta, 32'h7FE);
        chk("R4 restart strobe", tv, 1);
    endtask

    task automatic t_clear;
        wr(TX_C, 32'h50);
        rd_chk("R5 clear cfg", TX_C, 32'h0);
        rd_chk("R5 clear size", TX_S, 32'h0);
    endtask

    task automatic t_disabled;
        logic rv, rdn, tv, tdn; logic [11:0] ra, ta;
        wr(RX_A, 32'h200);
        wr(RX_S, 32'h4);
        wr(RX_C, 32'h0);
        pulse(1'b1, 1'b0, rv, ra, rdn, tv, ta, tdn);
        chk("R7 disabled no strobe", rv, 0);
        rd_chk("R7 disabled size", RX_S, 32'h4);
        rd_chk("R7 disabled addr", RX_A, 32'h200);
    endtask

    task automatic t_duplex;
        logic rv, rdn, tv, tdn; logic [11:0] ra, ta;
        wr(RX_C, 32'h10);
        wr(TX_A, 32'h300);
        wr(TX_S, 32'h5);
        wr(TX_C, 32'h10);
        pulse(1'b1, 1'b1, rv, ra, rdn, tv, ta, tdn);
        chk("R9 rx served", {rv, 3'b0, ra}, {1'b1, 3'b0, 12'h200});
        chk("R9 tx served", {tv, 3'b0, ta}, {1'b1, 3'b0, 12'h300});
        pulse(1'b1, 1'b0, rv, ra, rdn, tv, ta, tdn);
        rd_chk("R9 tx size held", TX_S, 32'h4);
        rd_chk("R9 rx size", RX_S, 32'h2);
    endtask

    task automatic t_collision;
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = RX_C; reg_wdata = 32'h10; rx_req = 1'b1;
        @(posedge clk);
        #1 chk("R10 no strobe on write cycle", rx_xfer_valid, 0);
        @(negedge clk);
        reg_wr = 1'b0; rx_req = 1'b0;
        rd_chk("R10 size held", RX_S, 32'h2);
        rd_chk("R10 addr held", RX_A, 32'h202);
    endtask

    task automatic t_unmapped;
        wr(6'h0C, 32'hFFFF_FFFF);
        wr(6'h20, 32'hFFFF_FFFF);
        rd_chk("R11 read 0x0C", 6'h0C, 0);
        rd_chk("R11 read 0x24", 6'h24, 0);
        rd_chk("R11 read 0x02", 6'h02, 0);
        rd_chk("R11 rx size untouched", RX_S, 32'h2);
        rd_chk("R11 tx size untouched", TX_S, 32'h4);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog all requirements actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        rx_req = 1'b0; tx_req = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_single_buffer();
        t_continuous();
        t_clear();
        t_disabled();
        t_duplex();
        t_collision();
        t_unmapped();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule